// File: doc/BRIEF.md
# Wake Event Power-Management Status Logic

This block holds the power-management control and status word of a network device and drives the power-management event (PME) request toward the platform. Three wake sources feed it: a magic-packet detector, a pattern-match detector and a link-state-change detector. A pulse on any of them sets a sticky status flag. The flag stays set until software clears it. The PME request is driven while that flag is set and software has enabled PME signalling.

Software reaches the word through a plain single-cycle register port that decodes one configuration offset. Through it software enables signalling, reads the status, clears it and sets the device power state. Clearing the status does not depend on the power-state field. Software may therefore clear the flag before it returns the device to the fully-on state, after that return, or in the same write, and the outcome on the PME line is the same. The PME line is active-low open-drain at the board. Here it is modelled as an output enable that pulls the line low while it is high.

The register port carries single control accesses and no data stream, so it has no valid/ready handshake. A write or a read takes effect in the cycle its strobe is high, and the block never stalls the port.

Top module: `pme_wake_ctrl`

## Requirements
- R1: After reset the power-state field is 00 (fully on), the enable bit and the status bit are 0, and `pme_oe` is 0.
- R2: If any bit of `wake_evt` is high at a rising clock edge, the status bit (read bit 15) is 1 from that edge on. Bit 0 is magic packet, bit 1 is pattern match and bit 2 is link change.
- R3: Once set, the status bit stays 1 after the event inputs return low, until software clears it.
- R4: A write to offset 0x44 with data bit 15 equal to 0 clears the status bit. A write with bit 15 equal to 1 leaves the status bit unchanged.
- R5: If a wake event and a clearing write fall on the same clock edge, the event wins and the status bit stays 1.
- R6: `pme_oe` is 1 exactly while both the status bit and the enable bit are 1. It falls in the cycle after the write that clears either bit.
- R7: The enable bit is write data bit 8 at offset 0x44 and reads back on bit 8.
- R8: The power-state field is write data bits 1:0 at offset 0x44 and accepts all four codes (00 fully on, 11 deepest sleep). A write to this field does not change the status bit, so the order of the status clear and the return to 00 does not affect the result.
- R9: A read at offset 0x44 returns the status on bit 15, the enable on bit 8 and the state on bits 1:0, with all other bits 0. A read at any other offset, or with no read strobe, returns 0. A write at any other offset changes nothing.
- R10: A wake event sets the status bit even while the enable bit is 0, and `pme_oe` then stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Configuration offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid in the cycle of `bus_rd` |
| wake_evt | input | 3 | Wake pulses: bit 0 magic packet, bit 1 pattern match, bit 2 link change |
| pme_oe | output | 1 | PME pull-down enable (high pulls the open-drain line low) |

## Verification
Two functions can land on the same clock edge: a wake pulse setting the status flag and a software write clearing it. The bench provokes this by raising a wake input in the same cycle as a write to offset 0x44 with bit 15 at 0. It then expects a readback of 0x8100 with `pme_oe` still high. It also orders the status clear before, after and together with the return to power state 00, and checks that each ordering leaves the same readback and PME level.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int unsigned ST_BIT  = 15;
  localparam int unsigned EN_BIT  = 8;
  localparam int unsigned PS_LSB  = 0;
  localparam int unsigned PS_W    = 2;
  localparam int unsigned WORD_W  = 16;

  typedef enum logic [PS_W-1:0] {
    PWR_ON    = 2'b00,
    PWR_LIGHT = 2'b01,
    PWR_DEEP  = 2'b10,
    PWR_OFF   = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/pme_reg_decode.sv
module pme_reg_decode
  import pme_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] OFFSET = 'h44
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              clr_req,
  output logic              en_wval,
  output logic [PS_W-1:0]   ps_wval
);
  logic addr_match;
  logic unused_wdata;

  assign addr_match   = (bus_addr == OFFSET);
  assign wr_hit       = bus_wr & addr_match;
  assign rd_hit       = bus_rd & addr_match;
  // writing zero into the status position requests a clear
  assign clr_req      = wr_hit & ~bus_wdata[ST_BIT];
  assign en_wval      = bus_wdata[EN_BIT];
  assign ps_wval      = bus_wdata[PS_LSB +: PS_W];
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/pme_status_cell.sv
module pme_status_cell #(
  parameter int unsigned N_EV = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] wake_evt,
  input  logic            clr_req,
  output logic            status_q,
  output logic            any_evt
);
  logic [N_EV:0] or_chain;

  assign or_chain[0] = 1'b0;
  for (genvar i = 0; i < N_EV; i++) begin : g_evt
    assign or_chain[i+1] = or_chain[i] | wake_evt[i];
  end
  assign any_evt = or_chain[N_EV];

  // an event on the same edge as a clear keeps the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= 1'b0;
    else if (any_evt)  status_q <= 1'b1;
    else if (clr_req)  status_q <= 1'b0;
  end
endmodule

// File: rtl/pme_ctrl_fields.sv
module pme_ctrl_fields
  import pme_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic            en_wval,
  input  logic [PS_W-1:0] ps_wval,
  output logic            en_q,
  output logic [PS_W-1:0] ps_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ps_q <= PWR_ON;
    end else if (wr_hit) begin
      en_q <= en_wval;
      ps_q <= ps_wval;
    end
  end
endmodule

// File: rtl/pme_read_mux.sv
module pme_read_mux
  import pme_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              rd_hit,
  input  logic              status_q,
  input  logic              en_q,
  input  logic [PS_W-1:0]   ps_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata[ST_BIT]            = status_q;
      rdata[EN_BIT]            = en_q;
      rdata[PS_LSB +: PS_W]    = ps_q;
    end
  end
endmodule

// File: rtl/pme_wake_ctrl.sv
module pme_wake_ctrl
  import pme_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned N_EV   = 3,
  parameter logic [ADDR_W-1:0] OFFSET = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_EV-1:0]   wake_evt,
  output logic              pme_oe
);
  logic            wr_hit, rd_hit, clr_req, en_wval;
  logic [PS_W-1:0] ps_wval, ps_q;
  logic            en_q, status_q, any_evt;

  pme_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .clr_req(clr_req),
    .en_wval(en_wval), .ps_wval(ps_wval)
  );

  pme_status_cell #(.N_EV(N_EV)) u_st (
    .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .clr_req(clr_req),
    .status_q(status_q), .any_evt(any_evt)
  );

  pme_ctrl_fields u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .en_wval(en_wval),
    .ps_wval(ps_wval), .en_q(en_q), .ps_q(ps_q)
  );

  pme_read_mux #(.DATA_W(DATA_W)) u_rd (
    .rd_hit(rd_hit), .status_q(status_q), .en_q(en_q), .ps_q(ps_q),
    .rdata(bus_rdata)
  );

  // PME follows only the sticky flag and the enable
  assign pme_oe = status_q & en_q;
endmodule

// File: rtl/pme_wake_ctrl_chk.sv
module pme_wake_ctrl_chk
  import pme_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] OFFSET = 'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pme_oe,
  input logic              any_evt,
  input logic              clr_req,
  input logic              status_q,
  input logic              en_q,
  input logic [PS_W-1:0]   ps_q
);
  logic [DATA_W-1:0] resv_mask;
  always_comb begin
    resv_mask = '1;
    resv_mask[ST_BIT] = 1'b0;
    resv_mask[EN_BIT] = 1'b0;
    resv_mask[PS_LSB +: PS_W] = '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!pme_oe && !status_q && !en_q && ps_q == PWR_ON));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> status_q);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr_req) |=> status_q);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !any_evt) |=> !status_q);

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && any_evt) |=> status_q);

  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pme_oe);

  p_resv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & resv_mask) == '0);

  p_foreign_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFFSET) |=> ($stable(en_q) && $stable(ps_q)));
endmodule

bind pme_wake_ctrl pme_wake_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .pme_oe(pme_oe), .any_evt(any_evt),
  .clr_req(clr_req), .status_q(status_q), .en_q(en_q), .ps_q(ps_q)
);

// File: tb/pme_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pme_wake_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic [2:0]  wake_evt = 3'b000;
  logic        pme_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  pme_wake_ctrl u_pme_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .wake_evt(wake_evt), .pme_oe(pme_oe)
  );

  // monitor: pops the scoreboard whenever a read strobe is seen
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (bus_rd) begin
        n_vec++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] v);
    @(negedge clk);
    wake_evt = v;
    @(negedge clk);
    wake_evt = 3'b000;
  endtask

  task automatic chk_pme(input logic e, input string t);
    @(negedge clk);
    #5;
    n_vec++;
    if (pme_oe !== e) begin
      n_bad++;
      $display("FAIL %s pme_oe actual=%b expected=%b", t, pme_oe, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h44, 16'h0000, "R1 reset word");
    chk_pme(1'b0, "R1 reset pme");

    // event with enable off
    pulse(3'b001);
    rd(8'h44, 16'h8000, "R2 R10 magic sets status");
    chk_pme(1'b0, "R10 pme held off");
    repeat (5) @(negedge clk);
    rd(8'h44, 16'h8000, "R3 status sticky");

    // enable, clear status in same write
    wr(8'h44, 16'h0100);
    rd(8'h44, 16'h0100, "R4 R7 clear and enable");
    chk_pme(1'b0, "R4 pme after clear");

    pulse(3'b010);
    rd(8'h44, 16'h8100, "R2 pattern sets status");
    chk_pme(1'b1, "R6 pme asserted");

    // deep state keeping status
    wr(8'h44, 16'h8103);
    rd(8'h44, 16'h8103, "R8 state 11 keep status");
    chk_pme(1'b1, "R4 write with bit15 keeps pme");
    // clear together with return to 00
    wr(8'h44, 16'h0100);
    rd(8'h44, 16'h0100, "R8 clear together");
    chk_pme(1'b0, "R6 pme drops with clear");

    // clear before return
    pulse(3'b100);
    wr(8'h44, 16'h8103);
    wr(8'h44, 16'h0103);
    rd(8'h44, 16'h0103, "R8 clear before return");
    chk_pme(1'b0, "R8 pme after early clear");
    wr(8'h44, 16'h0100);
    rd(8'h44, 16'h0100, "R8 return after clear");

    // clear after return
    pulse(3'b100);
    wr(8'h44, 16'h8103);
    wr(8'h44, 16'h8100);
    rd(8'h44, 16'h8100, "R8 return keeps status");
    chk_pme(1'b1, "R8 pme across state change");
    wr(8'h44, 16'h0100);
    rd(8'h44, 16'h0100, "R8 clear after return");

    // event and clear on the same edge
    @(negedge clk);
    wake_evt = 3'b001; bus_addr = 8'h44; bus_wr = 1'b1; bus_wdata = 16'h0100;
    @(negedge clk);
    wake_evt = 3'b000; bus_wr = 1'b0;
    rd(8'h44, 16'h8100, "R5 event wins over clear");
    chk_pme(1'b1, "R5 pme stays");

    // foreign offset
    wr(8'h48, 16'h0003);
    rd(8'h44, 16'h8100, "R9 foreign write ignored");
    rd(8'h48, 16'h0000, "R9 foreign read zero");
    @(negedge clk);
    n_vec++;
    if (bus_rdata !== 16'h0000) begin
      n_bad++;
      $display("FAIL R9 no strobe actual=%h expected=0000", bus_rdata);
    end

    // reserved bits
    wr(8'h44, 16'hFFFF);
    rd(8'h44, 16'h8103, "R9 R7 reserved read zero");
    wr(8'h44, 16'h0002);
    rd(8'h44, 16'h0002, "R7 R8 disable and state 10");
    chk_pme(1'b0, "R6 pme off with enable off");

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule